// File: doc/BRIEF.md
# In-Order Retirement Buffer with Interrupt Release

This block keeps the instructions of an out-of-order core in program order between dispatch and retirement. Dispatch claims one slot per cycle at the tail. The slot records the architectural destination, the physical register that destination named before the rename, whether a destination exists, and whether the instruction is an injected interrupt. Execution units report completion by slot index. On every cycle the buffer retires the run of completed slots that starts at the head, with no limit on how many. For each retiring slot it reports the architectural destination and, when a destination exists, the old physical register that may now be freed.

An interrupt enters the buffer as an ordinary slot that carries a marker. A two-state controller governs dispatch. In state `ORB_RUN`, dispatch is accepted while a slot is free. Accepting a marked slot takes the transition *inject* into `ORB_HOLD`. In that state dispatch is frozen, so nothing younger than the interrupt can enter the buffer. When the marked slot leaves the head, `intr_done` pulses and the transition *release* returns the controller to `ORB_RUN`. Because nothing younger than the interrupt was ever admitted, the core reaches a precise state without a flush.

Top module: `ordered_retire_buffer`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `full`=0, `occupancy`=0, `ret_count`=0, `freeze`=0 and `alloc_ready`=1.
- R2: A dispatch is accepted in a cycle where `alloc_valid` and `alloc_ready` are both high. The slot it takes is shown on `alloc_idx` in that cycle. Successive accepted slots step by one and wrap from DEPTH-1 to 0.
- R3: While `occupancy` equals DEPTH, `full`=1 and `alloc_ready`=0, and a request is not accepted. A slot retired in a cycle can be claimed from the next cycle on.
- R4: A completion marks the slot named by `cmpl_idx`. A completion aimed at a slot that holds no instruction has no effect: a later instruction placed in that slot still waits for its own completion.
- R5: Slots retire strictly in allocation order. In one cycle, every consecutive completed slot from the head retires. `ret_count` gives their number. Field k of `free_areg` (bits k*AREG_W and up) carries the destination of the k-th retiring slot.
- R6: A completion received in cycle X can cause retirement no earlier than cycle X+1.
- R7: Field k of `free_preg` (bits k*PREG_W and up), together with bit k of `free_vld`, returns the old physical register of the k-th retiring slot. `free_vld[k]` is 1 only when that slot had a destination. Unused fields are zero.
- R8: Accepting a request with `alloc_intr`=1 (transition *inject*) moves the controller to `ORB_HOLD` from the next cycle. In that state `freeze`=1 and `alloc_ready`=0.
- R9: In the cycle the interrupt slot retires, `intr_done`=1 and that slot frees no physical register. From the next cycle (transition *release*), `freeze`=0 and dispatch resumes.
- R10: Each cycle, `occupancy` grows by the number accepted and shrinks by `ret_count`. `empty` is 1 exactly when `occupancy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch requests a slot |
| alloc_intr | input | 1 | Request is an injected interrupt |
| alloc_has_dest | input | 1 | Request writes a destination register |
| alloc_areg | input | AREG_W | Architectural destination |
| alloc_prev_preg | input | PREG_W | Physical register previously mapped to the destination |
| alloc_ready | output | 1 | A request would be accepted this cycle |
| alloc_idx | output | IW | Slot given to the request (IW = clog2 DEPTH) |
| cmpl_valid | input | 1 | A completion is reported |
| cmpl_idx | input | IW | Slot that completed |
| ret_count | output | CW | Slots retiring this cycle (CW = clog2(DEPTH+1)) |
| free_vld | output | DEPTH | Per retire position: the old register is to be freed |
| free_preg | output | DEPTH*PREG_W | Per retire position: old physical register |
| free_areg | output | DEPTH*AREG_W | Per retire position: architectural destination |
| intr_done | output | 1 | Interrupt slot retires this cycle |
| freeze | output | 1 | Controller is in ORB_HOLD |
| occupancy | output | CW | Slots in use |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |

## Verification
The bench builds the buffer with DEPTH=4, AREG_W=3 and PREG_W=4. This makes it cheap to fill the buffer completely and then complete its four slots in every one of the 24 possible orders. Each order produces a different pattern of retirement bursts, from one slot per cycle up to all four in a single cycle, and the head pointer wraps at several offsets along the way. With so few slots, the bench can also reach these cases directly: retiring while full, completing an empty slot, and holding an interrupt behind older work. A long pseudo-random stream then mixes dispatch, completions and interrupts, and every output is compared each cycle against an arithmetic model of the queue.

// File: rtl/orb_pkg.sv
package orb_pkg;

    typedef enum logic {
        ORB_RUN  = 1'b0,
        ORB_HOLD = 1'b1
    } orb_state_e;

    // Modular step for a ring of d slots; v is below 2*d.
    function automatic int orb_wrap(input int v, input int d);
        return (v >= d) ? (v - d) : v;
    endfunction

endpackage

// File: rtl/orb_entries.sv
module orb_entries #(
    parameter int DEPTH  = 12,
    parameter int AREG_W = 5,
    parameter int PREG_W = 6,
    parameter int IW     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_en,
    input  logic [IW-1:0]                 alloc_slot,
    input  logic                          alloc_intr,
    input  logic                          alloc_has_dest,
    input  logic [AREG_W-1:0]             alloc_areg,
    input  logic [PREG_W-1:0]             alloc_prev,
    input  logic                          cmpl_en,
    input  logic [IW-1:0]                 cmpl_slot,
    input  logic [DEPTH-1:0]              ret_slots,
    output logic [DEPTH-1:0]              done_o,
    output logic [DEPTH-1:0]              intr_o,
    output logic [DEPTH-1:0]              hasd_o,
    output logic [DEPTH-1:0][AREG_W-1:0]  areg_o,
    output logic [DEPTH-1:0][PREG_W-1:0]  prev_o
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic              used_q;
        logic              done_q;
        logic              intr_q;
        logic              hasd_q;
        logic [AREG_W-1:0] areg_q;
        logic [PREG_W-1:0] prev_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                used_q <= 1'b0;
                done_q <= 1'b0;
                intr_q <= 1'b0;
                hasd_q <= 1'b0;
                areg_q <= '0;
                prev_q <= '0;
            end else if (ret_slots[g]) begin
                used_q <= 1'b0;
                done_q <= 1'b0;
            end else if (alloc_en && (alloc_slot == IW'(g))) begin
                used_q <= 1'b1;
                done_q <= 1'b0;
                intr_q <= alloc_intr;
                hasd_q <= alloc_has_dest;
                areg_q <= alloc_areg;
                prev_q <= alloc_prev;
            end else if (cmpl_en && (cmpl_slot == IW'(g)) && used_q) begin
                done_q <= 1'b1;
            end
        end

        assign done_o[g] = done_q;
        assign intr_o[g] = intr_q;
        assign hasd_o[g] = hasd_q;
        assign areg_o[g] = areg_q;
        assign prev_o[g] = prev_q;
    end

endmodule

// File: rtl/orb_scan.sv
module orb_scan
    import orb_pkg::*;
#(
    parameter int DEPTH  = 12,
    parameter int AREG_W = 5,
    parameter int PREG_W = 6,
    parameter int IW     = 4,
    parameter int CW     = 4
) (
    input  logic [IW-1:0]                 head,
    input  logic [CW-1:0]                 count,
    input  logic [DEPTH-1:0]              done,
    input  logic [DEPTH-1:0]              intr,
    input  logic [DEPTH-1:0]              hasd,
    input  logic [DEPTH-1:0][AREG_W-1:0]  areg,
    input  logic [DEPTH-1:0][PREG_W-1:0]  prev,
    output logic [DEPTH-1:0]              ret_slots,
    output logic [CW-1:0]                 ret_cnt,
    output logic [DEPTH-1:0]              free_vld,
    output logic [DEPTH*PREG_W-1:0]       free_preg,
    output logic [DEPTH*AREG_W-1:0]       free_areg,
    output logic                          intr_hit
);

    always_comb begin
        logic run;
        int   idx;
        int   n;
        run       = 1'b1;
        n         = 0;
        ret_slots = '0;
        free_vld  = '0;
        free_preg = '0;
        free_areg = '0;
        intr_hit  = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = orb_wrap(int'(head) + k, DEPTH);
            if (run && (k < int'(count)) && done[idx]) begin
                ret_slots[idx]              = 1'b1;
                free_areg[k*AREG_W +: AREG_W] = areg[idx];
                if (hasd[idx]) begin
                    free_vld[k]                   = 1'b1;
                    free_preg[k*PREG_W +: PREG_W] = prev[idx];
                end
                if (intr[idx]) begin
                    intr_hit = 1'b1;
                end
                n = n + 1;
            end else begin
                run = 1'b0;
            end
        end
        ret_cnt = CW'(n);
    end

endmodule

// File: rtl/orb_ctrl.sv
module orb_ctrl
    import orb_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int IW    = 4,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic          alloc_intr,
    input  logic [CW-1:0] ret_cnt,
    input  logic          intr_hit,
    output logic [IW-1:0] head,
    output logic [IW-1:0] tail,
    output logic [CW-1:0] count,
    output logic          alloc_fire,
    output logic          alloc_ready,
    output logic          full,
    output logic          empty,
    output logic          freeze,
    output logic          intr_done
);

    orb_state_e    state_q, state_d;
    logic [IW-1:0] head_q, tail_q;
    logic [CW-1:0] count_q;

    // State register and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ORB_RUN;
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            head_q  <= IW'(orb_wrap(int'(head_q) + int'(ret_cnt), DEPTH));
            if (alloc_fire) begin
                tail_q <= IW'(orb_wrap(int'(tail_q) + 1, DEPTH));
            end
            count_q <= CW'(int'(count_q) + int'(alloc_fire) - int'(ret_cnt));
        end
    end

    // Next state: inject (RUN->HOLD), release (HOLD->RUN)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ORB_RUN:  if (alloc_fire && alloc_intr) state_d = ORB_HOLD;
            ORB_HOLD: if (intr_hit)                 state_d = ORB_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        full        = (count_q == CW'(DEPTH));
        empty       = (count_q == '0);
        freeze      = (state_q == ORB_HOLD);
        alloc_ready = (state_q == ORB_RUN) && !full;
        alloc_fire  = alloc_valid && alloc_ready;
        intr_done   = (state_q == ORB_HOLD) && intr_hit;
        head        = head_q;
        tail        = tail_q;
        count       = count_q;
    end

endmodule

// File: rtl/ordered_retire_buffer.sv
module ordered_retire_buffer #(
    parameter  int DEPTH  = 12,
    parameter  int AREG_W = 5,
    parameter  int PREG_W = 6,
    localparam int IW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_valid,
    input  logic                     alloc_intr,
    input  logic                     alloc_has_dest,
    input  logic [AREG_W-1:0]        alloc_areg,
    input  logic [PREG_W-1:0]        alloc_prev_preg,
    output logic                     alloc_ready,
    output logic [IW-1:0]            alloc_idx,
    input  logic                     cmpl_valid,
    input  logic [IW-1:0]            cmpl_idx,
    output logic [CW-1:0]            ret_count,
    output logic [DEPTH-1:0]         free_vld,
    output logic [DEPTH*PREG_W-1:0]  free_preg,
    output logic [DEPTH*AREG_W-1:0]  free_areg,
    output logic                     intr_done,
    output logic                     freeze,
    output logic [CW-1:0]            occupancy,
    output logic                     full,
    output logic                     empty
);

    logic [IW-1:0]                head, tail;
    logic [CW-1:0]                count, ret_cnt;
    logic                         alloc_fire, intr_hit;
    logic [DEPTH-1:0]             ret_slots, done_v, intr_v, hasd_v;
    logic [DEPTH-1:0][AREG_W-1:0] areg_v;
    logic [DEPTH-1:0][PREG_W-1:0] prev_v;

    orb_ctrl #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_valid (alloc_valid),
        .alloc_intr  (alloc_intr),
        .ret_cnt     (ret_cnt),
        .intr_hit    (intr_hit),
        .head        (head),
        .tail        (tail),
        .count       (count),
        .alloc_fire  (alloc_fire),
        .alloc_ready (alloc_ready),
        .full        (full),
        .empty       (empty),
        .freeze      (freeze),
        .intr_done   (intr_done)
    );

    orb_entries #(.DEPTH(DEPTH), .AREG_W(AREG_W), .PREG_W(PREG_W), .IW(IW)) u_entries (
        .clk            (clk),
        .rst_n          (rst_n),
        .alloc_en       (alloc_fire),
        .alloc_slot     (tail),
        .alloc_intr     (alloc_intr),
        .alloc_has_dest (alloc_has_dest && !alloc_intr),
        .alloc_areg     (alloc_areg),
        .alloc_prev     (alloc_prev_preg),
        .cmpl_en        (cmpl_valid),
        .cmpl_slot      (cmpl_idx),
        .ret_slots      (ret_slots),
        .done_o         (done_v),
        .intr_o         (intr_v),
        .hasd_o         (hasd_v),
        .areg_o         (areg_v),
        .prev_o         (prev_v)
    );

    orb_scan #(.DEPTH(DEPTH), .AREG_W(AREG_W), .PREG_W(PREG_W), .IW(IW), .CW(CW)) u_scan (
        .head      (head),
        .count     (count),
        .done      (done_v),
        .intr      (intr_v),
        .hasd      (hasd_v),
        .areg      (areg_v),
        .prev      (prev_v),
        .ret_slots (ret_slots),
        .ret_cnt   (ret_cnt),
        .free_vld  (free_vld),
        .free_preg (free_preg),
        .free_areg (free_areg),
        .intr_hit  (intr_hit)
    );

    assign alloc_idx = tail;
    assign ret_count = ret_cnt;
    assign occupancy = count;

endmodule

// File: rtl/orb_checker.sv
module orb_checker #(
    parameter int DEPTH = 12,
    parameter int CW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             alloc_intr,
    input logic             alloc_ready,
    input logic [CW-1:0]    ret_count,
    input logic [DEPTH-1:0] free_vld,
    input logic             intr_done,
    input logic             freeze,
    input logic [CW-1:0]    occupancy,
    input logic             empty
);

    // R10
    occ_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (int'(occupancy) == int'($past(occupancy))
                          + int'($past(alloc_valid && alloc_ready))
                          - int'($past(ret_count))));

    // R3
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occupancy) <= DEPTH);

    // R8
    freeze_after_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready && alloc_intr) |=> (freeze && !alloc_ready));

    // R9
    release_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr_done |=> !freeze);

    // R5
    empty_no_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (ret_count == '0));

    // R7
    free_within_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(free_vld) <= int'(ret_count));

endmodule

bind ordered_retire_buffer orb_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .alloc_intr  (alloc_intr),
    .alloc_ready (alloc_ready),
    .ret_count   (ret_count),
    .free_vld    (free_vld),
    .intr_done   (intr_done),
    .freeze      (freeze),
    .occupancy   (occupancy),
    .empty       (empty)
);

// File: tb/ordered_retire_buffer_tb.sv
`timescale 1ns/1ps
module ordered_retire_buffer_tb;

    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0, alloc_intr = 1'b0, alloc_has_dest = 1'b0;
    logic [2:0]  alloc_areg = '0;
    logic [3:0]  alloc_prev_preg = '0;
    logic        alloc_ready;
    logic [1:0]  alloc_idx;
    logic        cmpl_valid = 1'b0;
    logic [1:0]  cmpl_idx = '0;
    logic [2:0]  ret_count;
    logic [3:0]  free_vld;
    logic [15:0] free_preg;
    logic [11:0] free_areg;
    logic        intr_done, freeze, full, empty;
    logic [2:0]  occupancy;

    ordered_retire_buffer #(.DEPTH(D), .AREG_W(3), .PREG_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_intr(alloc_intr),
        .alloc_has_dest(alloc_has_dest), .alloc_areg(alloc_areg),
        .alloc_prev_preg(alloc_prev_preg), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx), .ret_count(ret_count),
        .free_vld(free_vld), .free_preg(free_preg), .free_areg(free_areg),
        .intr_done(intr_done), .freeze(freeze), .occupancy(occupancy),
        .full(full), .empty(empty)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad   = 0;
    string ret_tag = "R5";

    // Reference queue model
    bit [3:0] m_used = '0, m_done = '0, m_intr = '0, m_hd = '0;
    bit [2:0] m_ar[D];
    bit [3:0] m_pp[D];
    int       m_head = 0, m_tail = 0, m_cnt = 0;
    bit       m_frz = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input bit av, input bit ai, input bit ahd, input bit [2:0] aa,
                       input bit [3:0] ap, input bit cv, input bit [1:0] ci);
        bit        exp_ready, run, e_int;
        int        e_cnt;
        bit [3:0]  e_fv, rs;
        bit [15:0] e_fp;
        bit [11:0] e_fa;
        @(negedge clk);
        alloc_valid = av; alloc_intr = ai; alloc_has_dest = ahd;
        alloc_areg = aa; alloc_prev_preg = ap; cmpl_valid = cv; cmpl_idx = ci;
        #1;
        exp_ready = (m_cnt < D) && !m_frz;
        e_cnt = 0; run = 1'b1; e_fv = '0; e_fp = '0; e_fa = '0; e_int = 1'b0; rs = '0;
        for (int k = 0; k < D; k++) begin
            int idx;
            idx = (m_head + k) % D;
            if (run && (k < m_cnt) && m_done[idx]) begin
                rs[idx] = 1'b1;
                e_cnt++;
                e_fa[k*3 +: 3] = m_ar[idx];
                if (m_hd[idx]) begin
                    e_fv[k] = 1'b1;
                    e_fp[k*4 +: 4] = m_pp[idx];
                end
                if (m_intr[idx]) e_int = 1'b1;
            end else begin
                run = 1'b0;
            end
        end
        chk(alloc_ready == exp_ready, m_frz ? "R8 alloc_ready" : "R3 alloc_ready",
            int'(alloc_ready), int'(exp_ready));
        chk(full == (m_cnt == D), "R3 full", int'(full), int'(m_cnt == D));
        chk(alloc_idx == 2'(m_tail), "R2 alloc_idx", int'(alloc_idx), m_tail);
        chk(int'(occupancy) == m_cnt, "R10 occupancy", int'(occupancy), m_cnt);
        chk(empty == (m_cnt == 0), "R10 empty", int'(empty), int'(m_cnt == 0));
        chk(int'(ret_count) == e_cnt, ret_tag, int'(ret_count), e_cnt);
        chk(free_areg == e_fa, "R5 free_areg", int'(free_areg), int'(e_fa));
        chk(free_vld == e_fv, "R7 free_vld", int'(free_vld), int'(e_fv));
        chk(free_preg == e_fp, "R7 free_preg", int'(free_preg), int'(e_fp));
        chk(intr_done == e_int, "R9 intr_done", int'(intr_done), int'(e_int));
        chk(freeze == m_frz, "R8 freeze", int'(freeze), int'(m_frz));
        // model update: completion on pre-state, then retirement, then allocation
        if (cv && m_used[ci]) m_done[ci] = 1'b1;
        for (int s = 0; s < D; s++) begin
            if (rs[s]) begin
                m_used[s] = 1'b0;
                m_done[s] = 1'b0;
            end
        end
        m_head = (m_head + e_cnt) % D;
        m_cnt  = m_cnt - e_cnt;
        if (e_int) m_frz = 1'b0;
        if (av && exp_ready) begin
            m_used[m_tail] = 1'b1; m_done[m_tail] = 1'b0;
            m_intr[m_tail] = ai;   m_hd[m_tail] = ahd && !ai;
            m_ar[m_tail] = aa;     m_pp[m_tail] = ap;
            m_tail = (m_tail + 1) % D;
            m_cnt++;
            if (ai) m_frz = 1'b1;
        end
        @(posedge clk);
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 1'b0, 3'd0, 4'd0, 1'b0, 2'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int        ord[4];
        bit [3:0]  taken;
        int        f, pick, base, seed;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(empty == 1'b1, "R1 empty", int'(empty), 1);
        chk(full == 1'b0, "R1 full", int'(full), 0);
        chk(occupancy == '0, "R1 occupancy", int'(occupancy), 0);
        chk(ret_count == '0, "R1 ret_count", int'(ret_count), 0);
        chk(freeze == 1'b0, "R1 freeze", int'(freeze), 0);
        chk(alloc_ready == 1'b1, "R1 alloc_ready", int'(alloc_ready), 1);

        // R6: completion reaches retirement one cycle later
        ret_tag = "R6";
        cyc(1'b1, 1'b0, 1'b1, 3'd5, 4'd9, 1'b0, 2'd0);
        cyc(1'b0, 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, 2'(m_head));
        idle();
        ret_tag = "R5";

        // R3/R5/R7: every completion order over a full buffer
        for (int p = 0; p < 24; p++) begin
            taken = '0;
            f = p;
            for (int j = 0; j < 4; j++) begin
                pick = f % (4 - j);
                f = f / (4 - j);
                for (int s = 0; s < 4; s++) begin
                    if (!taken[s]) begin
                        if (pick == 0) begin
                            ord[j] = s;
                            taken[s] = 1'b1;
                        end
                        pick--;
                    end
                end
            end
            base = m_tail;
            for (int i = 0; i < 4; i++)
                cyc(1'b1, 1'b0, ((p + i) % 3) != 0, 3'(p + i), 4'(p * 3 + i), 1'b0, 2'd0);
            cyc(1'b1, 1'b0, 1'b1, 3'd7, 4'd15, 1'b0, 2'd0);   // R3 refused while full
            for (int j = 0; j < 4; j++)
                cyc((p % 2) == 1, 1'b0, 1'b1, 3'(j), 4'(j + 8), 1'b1, 2'((base + ord[j]) % D));
            idle();
            idle();
            while (m_cnt != 0) begin
                cyc(1'b0, 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, 2'(m_head));
            end
            idle();
        end

        // R4: completion to an empty slot is ignored
        cyc(1'b0, 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, 2'(m_tail));
        cyc(1'b1, 1'b0, 1'b1, 3'd2, 4'd6, 1'b0, 2'd0);
        idle();
        chk(int'(ret_count) == 0 && occupancy == 3'd1, "R4 stale completion", int'(ret_count), 0);
        cyc(1'b0, 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, 2'(m_head));
        idle();

        // R8/R9: interrupt held behind older work
        base = m_tail;
        cyc(1'b1, 1'b0, 1'b1, 3'd1, 4'd11, 1'b0, 2'd0);
        cyc(1'b1, 1'b0, 1'b1, 3'd2, 4'd12, 1'b0, 2'd0);
        cyc(1'b1, 1'b1, 1'b1, 3'd3, 4'd13, 1'b0, 2'd0);
        cyc(1'b1, 1'b0, 1'b1, 3'd4, 4'd14, 1'b0, 2'd0);   // R8 frozen
        cyc(1'b1, 1'b0, 1'b1, 3'd4, 4'd14, 1'b1, 2'((base + 2) % D));
        cyc(1'b1, 1'b0, 1'b1, 3'd4, 4'd14, 1'b1, 2'((base + 1) % D));
        cyc(1'b1, 1'b0, 1'b1, 3'd4, 4'd14, 1'b1, 2'(base % D));
        cyc(1'b1, 1'b0, 1'b1, 3'd4, 4'd14, 1'b0, 2'd0);   // R9 retire burst with interrupt
        cyc(1'b1, 1'b0, 1'b1, 3'd5, 4'd3, 1'b0, 2'd0);    // R9 dispatch resumes
        // lone interrupt
        cyc(1'b0, 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, 2'(m_head));
        idle();
        base = m_tail;
        cyc(1'b1, 1'b1, 1'b1, 3'd6, 4'd7, 1'b0, 2'd0);
        cyc(1'b0, 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, 2'(base));
        idle();
        idle();

        // Mixed stream
        seed = 32'h1234;
        for (int i = 0; i < 400; i++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            cyc(seed[16] | seed[17], seed[21:18] == 4'd0, seed[22], 3'(seed[25:23]),
                4'(seed[29:26]), seed[11] | seed[12], 2'(seed[14:13]));
        end
        for (int i = 0; i < 12; i++) begin
            cyc(1'b0, 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, 2'(i % D));
        end
        idle();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule